// File: doc/BRIEF.md
# Retry-Persistent Bus Master with Deferred Soft Reset

This block drives read and write requests from local logic onto a simple parallel bus. It holds one request at a time. The target ends each attempt with either a completion or a retry. After a retry the master pauses for one cycle and then issues the same request again, with the same address, direction and write data. There is no limit on the number of attempts. A read and a write are treated the same way.

Software can ask for an internal reset by pulsing a register strobe. The request is latched as pending at once, and new local requests are refused from then on. The reset itself is held back until the engine is idle and its count of retried-but-unfinished requests is zero, so no retried transaction is ever dropped. When the reset is applied, the engine is disabled. If a configuration bit is set, a quiet window of 2^QUIET_LOG2 clocks follows, and during it an enable strobe has no effect. The engine runs again only after software writes the enable strobe.

The bus-wide reset `bus_rst` is synchronous and active-high. It is the only way to abandon an outstanding request. At the next clock edge it clears the request, the retry count, the pending reset, the quiet window and the enable.

Top module: `rpm_top`

## Requirements
- R1: `lreq_ready` is high only when the engine is enabled, no soft reset is pending, and no request is held. A request accepted at an edge drives `bus_req` high in the next cycle, with its address, direction and data on the bus.
- R2: When the target answers an attempt with `bus_retry` (and without `bus_done`), `bus_req` goes low for exactly one cycle. It then rises again with the same `bus_addr`, `bus_write` and `bus_wdata`. This repeats for any number of retries.
- R3: When the target answers with `bus_done`, `rsp_valid` is high for one cycle in the next cycle, and `rsp_rdata` equals the `bus_rdata` that was sampled with the completion.
- R4: `stat_retry_cnt` becomes 1 in the cycle after the first retry of a request. It keeps that value through further retries and returns to 0 in the cycle after that request completes.
- R5: A pulse on `sw_rst_strobe` sets `stat_rst_pending` in the next cycle. While the bit is set, `lreq_ready` stays low.
- R6: The pending reset is applied one cycle after the engine is idle with a zero retry count. A request that is being retried still runs to completion first. When the reset is applied, `stat_rst_pending` and `stat_enabled` both clear.
- R7: If `cfg_quiet_en` is 1 when the reset is applied, `stat_quiet` is high for exactly 2^QUIET_LOG2 cycles starting in the next cycle. An enable strobe given in that window leaves `stat_enabled` at 0.
- R8: If `cfg_quiet_en` is 0, there is no quiet window, and an enable strobe given right after the reset is applied sets `stat_enabled` in the next cycle.
- R9: `bus_rst` high at an edge clears `bus_req`, `stat_retry_cnt`, `stat_rst_pending`, `stat_quiet`, `stat_enabled` and `rsp_valid` from the next cycle on. Any held request is dropped.
- R10: A write request follows the same retry and reset-deferral rules as a read, and its write data is repeated unchanged on every attempt.
- R11: After `bus_rst`, the engine is disabled and idle: `lreq_ready` is 0 and `bus_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Bus-wide synchronous reset, active high |
| cfg_quiet_en | input | 1 | Use the quiet window after a soft reset |
| sw_rst_strobe | input | 1 | Register pulse that requests an internal reset |
| sw_enable_strobe | input | 1 | Register pulse that enables the engine |
| lreq_valid | input | 1 | Local request present |
| lreq_ready | output | 1 | Local request can be taken |
| lreq_write | input | 1 | 1 = write, 0 = read |
| lreq_addr | input | 32 | Request address |
| lreq_wdata | input | 32 | Write data |
| bus_req | output | 1 | Attempt in progress on the bus |
| bus_write | output | 1 | Direction of the attempt |
| bus_addr | output | 32 | Address of the attempt |
| bus_wdata | output | 32 | Write data of the attempt |
| bus_done | input | 1 | Target completes the attempt |
| bus_retry | input | 1 | Target asks for a retry |
| bus_rdata | input | 32 | Data returned with the completion |
| rsp_valid | output | 1 | One-cycle completion pulse to local logic |
| rsp_rdata | output | 32 | Data captured with the completion |
| stat_enabled | output | 1 | Engine is enabled |
| stat_rst_pending | output | 1 | A soft reset is waiting to be applied |
| stat_quiet | output | 1 | Quiet window is running |
| stat_retry_cnt | output | CNT_W | Count of retried requests not yet complete |

## Verification
A corrupted held request shows up as a changed address, direction or data on the very next reissue after a retry. The bus model compares every reissue with the first attempt. A retry counter that is off by one, or not cleared, shows up at the status port in the next cycle. It also delays the soft reset, so `stat_rst_pending` stays high past the completion. A reset that fires too early drops the request: the scoreboard then waits for a response that never arrives, or sees `stat_enabled` fall while `rsp_valid` has not yet pulsed. A quiet counter that is wrong changes the number of cycles in which `stat_quiet` is high, and that number is counted exactly.

// File: rtl/rpm_pkg.sv
package rpm_pkg;

    localparam int RPM_ADDR_W = 32;
    localparam int RPM_DATA_W = 32;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_ISSUE = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic                  write;
        logic [RPM_ADDR_W-1:0] addr;
        logic [RPM_DATA_W-1:0] wdata;
    } rpm_req_t;

    function automatic rpm_req_t rpm_make_req(
        input logic                  write,
        input logic [RPM_ADDR_W-1:0] addr,
        input logic [RPM_DATA_W-1:0] wdata
    );
        rpm_req_t r;
        r.write = write;
        r.addr  = addr;
        r.wdata = wdata;
        return r;
    endfunction

endpackage

// File: rtl/rpm_issue.sv
module rpm_issue
    import rpm_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  rpm_req_t              req_in,
    input  logic                  bus_done,
    input  logic                  bus_retry,
    input  logic [RPM_DATA_W-1:0] bus_rdata,
    output logic                  bus_req,
    output rpm_req_t              held,
    output logic                  idle,
    output logic                  rsp_valid,
    output logic [RPM_DATA_W-1:0] rsp_rdata,
    output logic [CNT_W-1:0]      retry_cnt
);

    eng_state_e state;
    logic       retried;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            held      <= '0;
            retried   <= 1'b0;
            retry_cnt <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (accept) begin
                        held    <= req_in;
                        retried <= 1'b0;
                        state   <= ENG_ISSUE;
                    end
                end
                ENG_ISSUE: begin
                    if (bus_done) begin
                        state     <= ENG_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= bus_rdata;
                        retried   <= 1'b0;
                        if (retried) begin
                            retry_cnt <= retry_cnt - CNT_W'(1);
                        end
                    end else if (bus_retry) begin
                        state <= ENG_GAP;
                        if (!retried) begin
                            retried   <= 1'b1;
                            retry_cnt <= retry_cnt + CNT_W'(1);
                        end
                    end
                end
                ENG_GAP: begin
                    state <= ENG_ISSUE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign bus_req = (state == ENG_ISSUE);
    assign idle    = (state == ENG_IDLE);

endmodule

// File: rtl/rpm_reset_gate.sv
module rpm_reset_gate #(
    parameter int QUIET_LOG2 = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic sw_rst_strobe,
    input  logic sw_enable_strobe,
    input  logic cfg_quiet_en,
    input  logic engine_drained,
    output logic apply,
    output logic enabled,
    output logic pending,
    output logic quiet
);

    localparam int            QW        = QUIET_LOG2 + 1;
    localparam logic [QW-1:0] QUIET_LEN = QW'(1) << QUIET_LOG2;

    logic [QW-1:0] quiet_cnt;

    assign apply = pending && engine_drained;
    assign quiet = (quiet_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            enabled   <= 1'b0;
            quiet_cnt <= '0;
        end else begin
            if (sw_rst_strobe) begin
                pending <= 1'b1;
            end else if (apply) begin
                pending <= 1'b0;
            end

            if (apply) begin
                enabled <= 1'b0;
            end else if (sw_enable_strobe && !quiet) begin
                enabled <= 1'b1;
            end

            if (apply && cfg_quiet_en) begin
                quiet_cnt <= QUIET_LEN;
            end else if (quiet) begin
                quiet_cnt <= quiet_cnt - QW'(1);
            end
        end
    end

endmodule

// File: rtl/rpm_top.sv
module rpm_top
    import rpm_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int QUIET_LOG2 = 15
) (
    input  logic                  clk,
    input  logic                  bus_rst,
    input  logic                  cfg_quiet_en,
    input  logic                  sw_rst_strobe,
    input  logic                  sw_enable_strobe,
    input  logic                  lreq_valid,
    output logic                  lreq_ready,
    input  logic                  lreq_write,
    input  logic [RPM_ADDR_W-1:0] lreq_addr,
    input  logic [RPM_DATA_W-1:0] lreq_wdata,
    output logic                  bus_req,
    output logic                  bus_write,
    output logic [RPM_ADDR_W-1:0] bus_addr,
    output logic [RPM_DATA_W-1:0] bus_wdata,
    input  logic                  bus_done,
    input  logic                  bus_retry,
    input  logic [RPM_DATA_W-1:0] bus_rdata,
    output logic                  rsp_valid,
    output logic [RPM_DATA_W-1:0] rsp_rdata,
    output logic                  stat_enabled,
    output logic                  stat_rst_pending,
    output logic                  stat_quiet,
    output logic [CNT_W-1:0]      stat_retry_cnt
);

    rpm_req_t req_in;
    rpm_req_t held;
    logic     idle;
    logic     apply;
    logic     drained;
    logic     accept;
    logic     issue_rst;

    assign req_in     = rpm_make_req(lreq_write, lreq_addr, lreq_wdata);
    assign lreq_ready = stat_enabled && !stat_rst_pending && idle;
    assign accept     = lreq_valid && lreq_ready;
    assign drained    = idle && (stat_retry_cnt == '0);
    assign issue_rst  = bus_rst || apply;

    rpm_issue #(
        .CNT_W(CNT_W)
    ) u_issue (
        .clk      (clk),
        .rst      (issue_rst),
        .accept   (accept),
        .req_in   (req_in),
        .bus_done (bus_done),
        .bus_retry(bus_retry),
        .bus_rdata(bus_rdata),
        .bus_req  (bus_req),
        .held     (held),
        .idle     (idle),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .retry_cnt(stat_retry_cnt)
    );

    rpm_reset_gate #(
        .QUIET_LOG2(QUIET_LOG2)
    ) u_gate (
        .clk             (clk),
        .rst             (bus_rst),
        .sw_rst_strobe   (sw_rst_strobe),
        .sw_enable_strobe(sw_enable_strobe),
        .cfg_quiet_en    (cfg_quiet_en),
        .engine_drained  (drained),
        .apply           (apply),
        .enabled         (stat_enabled),
        .pending         (stat_rst_pending),
        .quiet           (stat_quiet)
    );

    assign bus_write = held.write;
    assign bus_addr  = held.addr;
    assign bus_wdata = held.wdata;

endmodule

// File: rtl/rpm_checker.sv
module rpm_checker
    import rpm_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int QUIET_LOG2 = 15
) (
    input logic                  clk,
    input logic                  bus_rst,
    input logic                  lreq_valid,
    input logic                  lreq_ready,
    input logic                  bus_req,
    input logic                  bus_write,
    input logic [RPM_ADDR_W-1:0] bus_addr,
    input logic [RPM_DATA_W-1:0] bus_wdata,
    input logic                  bus_done,
    input logic                  bus_retry,
    input logic                  rsp_valid,
    input logic                  stat_enabled,
    input logic                  stat_rst_pending,
    input logic                  stat_quiet,
    input logic [CNT_W-1:0]      stat_retry_cnt
);

    localparam int            RW       = QUIET_LOG2 + 2;
    localparam logic [RW-1:0] QUIET_EXP = RW'(1) << QUIET_LOG2;

    logic [RW-1:0] qrun;

    always_ff @(posedge clk) begin
        if (bus_rst) begin
            qrun <= '0;
        end else if (stat_quiet) begin
            qrun <= qrun + RW'(1);
        end else begin
            qrun <= '0;
        end
    end

    assert_issue_after_accept_R1: assert property (@(posedge clk) disable iff (bus_rst)
        (lreq_valid && lreq_ready) |=> bus_req);

    assert_gap_after_retry_R2: assert property (@(posedge clk) disable iff (bus_rst)
        (bus_req && bus_retry && !bus_done) |=> !bus_req);

    assert_reissue_same_R2: assert property (@(posedge clk) disable iff (bus_rst)
        (!bus_req && $past(bus_req && bus_retry && !bus_done)) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));

    assert_rsp_after_done_R3: assert property (@(posedge clk) disable iff (bus_rst)
        (bus_req && bus_done) |=> rsp_valid);

    assert_count_after_retry_R4: assert property (@(posedge clk) disable iff (bus_rst)
        (bus_req && bus_retry && !bus_done) |=> (stat_retry_cnt != '0));

    assert_no_accept_pending_R5: assert property (@(posedge clk) disable iff (bus_rst)
        lreq_ready |-> !stat_rst_pending);

    assert_apply_when_drained_R6: assert property (@(posedge clk) disable iff (bus_rst)
        ($fell(stat_rst_pending) && !$past(bus_rst)) |->
            ($past(stat_retry_cnt) == '0 && !$past(bus_req)));

    assert_quiet_len_R7: assert property (@(posedge clk) disable iff (bus_rst)
        ($fell(stat_quiet) && !$past(bus_rst)) |-> (qrun == QUIET_EXP));

    assert_quiet_disabled_R7: assert property (@(posedge clk) disable iff (bus_rst)
        stat_quiet |-> !stat_enabled);

    assert_bus_reset_clears_R9: assert property (@(posedge clk)
        $past(bus_rst) |-> (!bus_req && stat_retry_cnt == '0 && !stat_rst_pending
                            && !stat_quiet && !stat_enabled && !rsp_valid));

endmodule

bind rpm_top rpm_checker #(
    .CNT_W     (CNT_W),
    .QUIET_LOG2(QUIET_LOG2)
) u_rpm_checker (
    .clk             (clk),
    .bus_rst         (bus_rst),
    .lreq_valid      (lreq_valid),
    .lreq_ready      (lreq_ready),
    .bus_req         (bus_req),
    .bus_write       (bus_write),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_done        (bus_done),
    .bus_retry       (bus_retry),
    .rsp_valid       (rsp_valid),
    .stat_enabled    (stat_enabled),
    .stat_rst_pending(stat_rst_pending),
    .stat_quiet      (stat_quiet),
    .stat_retry_cnt  (stat_retry_cnt)
);

// File: tb/test_rpm_top.sv
module test_rpm_top;
    import rpm_pkg::*;

    localparam int QL    = 6;
    localparam int CNT_W = 4;

    logic                  clk = 1'b0;
    logic                  bus_rst = 1'b1;
    logic                  cfg_quiet_en = 1'b0;
    logic                  sw_rst_strobe = 1'b0;
    logic                  sw_enable_strobe = 1'b0;
    logic                  lreq_valid = 1'b0;
    logic                  lreq_ready;
    logic                  lreq_write = 1'b0;
    logic [RPM_ADDR_W-1:0] lreq_addr = '0;
    logic [RPM_DATA_W-1:0] lreq_wdata = '0;
    logic                  bus_req;
    logic                  bus_write;
    logic [RPM_ADDR_W-1:0] bus_addr;
    logic [RPM_DATA_W-1:0] bus_wdata;
    logic                  bus_done = 1'b0;
    logic                  bus_retry = 1'b0;
    logic [RPM_DATA_W-1:0] bus_rdata = '0;
    logic                  rsp_valid;
    logic [RPM_DATA_W-1:0] rsp_rdata;
    logic                  stat_enabled;
    logic                  stat_rst_pending;
    logic                  stat_quiet;
    logic [CNT_W-1:0]      stat_retry_cnt;

    always #4 clk = ~clk;

    rpm_top #(.CNT_W(CNT_W), .QUIET_LOG2(QL)) i_rpm_top (
        .clk(clk), .bus_rst(bus_rst), .cfg_quiet_en(cfg_quiet_en),
        .sw_rst_strobe(sw_rst_strobe), .sw_enable_strobe(sw_enable_strobe),
        .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_write(lreq_write),
        .lreq_addr(lreq_addr), .lreq_wdata(lreq_wdata),
        .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_retry(bus_retry),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .stat_enabled(stat_enabled), .stat_rst_pending(stat_rst_pending),
        .stat_quiet(stat_quiet), .stat_retry_cnt(stat_retry_cnt)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tgt_data(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    // Scoreboard of expected completion data
    logic [31:0] exp_q[$];

    // Bus target model: retries a set number of times, then completes
    int          retries_left = 0;
    bit          seen_retry = 1'b0;
    bit          prev_retry = 1'b0;
    bit          mdl_on = 1'b1;
    int          exp_cnt = 0;
    logic [64:0] first_attr = '0;

    always @(negedge clk) begin
        if (mdl_on) begin
            chk("R4 retry count", 65'(stat_retry_cnt), 65'(exp_cnt));
            if (prev_retry) chk("R2 one-cycle gap after retry", 65'(bus_req), 65'(0));
        end
        prev_retry = 1'b0;
        bus_done   = 1'b0;
        bus_retry  = 1'b0;
        bus_rdata  = '0;
        if (bus_req && mdl_on) begin
            // R10: writes are compared the same way, data included
            if (seen_retry) chk("R2 R10 reissue attributes", {bus_write, bus_addr, bus_wdata}, first_attr);
            else first_attr = {bus_write, bus_addr, bus_wdata};
            if (retries_left > 0) begin
                bus_retry = 1'b1;
                retries_left--;
                if (!seen_retry) exp_cnt = 1;
                seen_retry = 1'b1;
                prev_retry = 1'b1;
            end else begin
                bus_done   = 1'b1;
                bus_rdata  = tgt_data(bus_addr);
                exp_cnt    = 0;
                seen_retry = 1'b0;
            end
        end
    end

    // Monitor: pops the scoreboard on each completion
    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R3 unexpected response actual=%0h expected=none", rsp_rdata);
            end else begin
                chk("R3 response data", 65'(rsp_rdata), 65'(exp_q.pop_front()));
            end
        end
    end

    task automatic send(input bit w, input logic [31:0] a, input logic [31:0] d, input int nr);
        while (!lreq_ready) @(negedge clk);
        retries_left = nr;
        lreq_valid   = 1'b1;
        lreq_write   = w;
        lreq_addr    = a;
        lreq_wdata   = d;
        exp_q.push_back(tgt_data(a));
        @(negedge clk);
        lreq_valid = 1'b0;
        chk("R1 bus_req after accept", 65'(bus_req), 65'(1));
        chk("R1 bus attributes", {bus_write, bus_addr, bus_wdata}, {w, a, d});
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_enable();
        sw_enable_strobe = 1'b1;
        @(negedge clk);
        sw_enable_strobe = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        bus_rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk("R11 enabled", 65'(stat_enabled), 65'(0));
        chk("R11 pending", 65'(stat_rst_pending), 65'(0));
        chk("R11 quiet", 65'(stat_quiet), 65'(0));
        chk("R11 lreq_ready", 65'(lreq_ready), 65'(0));
        chk("R11 bus_req", 65'(bus_req), 65'(0));

        // R1 no acceptance while disabled
        lreq_valid = 1'b1;
        lreq_addr  = 32'h0000_0ABC;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 disabled no issue", 65'(bus_req), 65'(0));
        end
        lreq_valid = 1'b0;

        pulse_enable();
        chk("R1 enabled", 65'(stat_enabled), 65'(1));
        chk("R1 ready when enabled", 65'(lreq_ready), 65'(1));

        // R2 R3 R10 mixed traffic
        send(1'b0, 32'h0000_0100, 32'h0, 0);
        send(1'b0, 32'h0000_0204, 32'h0, 3);
        send(1'b1, 32'h0000_0308, 32'hDEAD_BEEF, 5);
        send(1'b1, 32'h0000_040C, 32'h0000_1234, 0);
        send(1'b0, 32'h0000_0510, 32'h0, 200);
        drain();

        // R5 R6 R8 soft reset deferred behind a retried write
        cfg_quiet_en = 1'b0;
        send(1'b1, 32'h0000_0600, 32'h0000_CAFE, 30);
        repeat (4) @(negedge clk);
        sw_rst_strobe = 1'b1;
        @(negedge clk);
        sw_rst_strobe = 1'b0;
        chk("R5 pending set", 65'(stat_rst_pending), 65'(1));
        chk("R5 ready blocked", 65'(lreq_ready), 65'(0));
        while (!rsp_valid) begin
            chk("R6 still deferred", 65'(stat_rst_pending), 65'(1));
            @(negedge clk);
        end
        chk("R6 pending at completion", 65'(stat_rst_pending), 65'(1));
        chk("R6 enabled at completion", 65'(stat_enabled), 65'(1));
        @(negedge clk);
        chk("R6 pending cleared", 65'(stat_rst_pending), 65'(0));
        chk("R6 disabled by reset", 65'(stat_enabled), 65'(0));
        chk("R8 no quiet", 65'(stat_quiet), 65'(0));
        pulse_enable();
        chk("R8 enable taken", 65'(stat_enabled), 65'(1));

        // R7 quiet window
        cfg_quiet_en  = 1'b1;
        sw_rst_strobe = 1'b1;
        @(negedge clk);
        sw_rst_strobe = 1'b0;
        chk("R7 pending set", 65'(stat_rst_pending), 65'(1));
        @(negedge clk);
        chk("R7 pending cleared", 65'(stat_rst_pending), 65'(0));
        begin
            int q = 0;
            bit saw_en = 1'b0;
            while (stat_quiet && q < 1000) begin
                q++;
                sw_enable_strobe = (q == 10) || (q == (1 << QL));
                @(negedge clk);
                if (stat_enabled) saw_en = 1'b1;
            end
            sw_enable_strobe = 1'b0;
            chk("R7 quiet length", 65'(q), 65'(1 << QL));
            chk("R7 enable ignored in quiet", 65'(saw_en), 65'(0));
        end
        chk("R7 still disabled", 65'(stat_enabled), 65'(0));
        chk("R7 ready low", 65'(lreq_ready), 65'(0));
        pulse_enable();
        chk("R7 enable after quiet", 65'(stat_enabled), 65'(1));

        // R9 bus-wide reset abandons a retried request
        cfg_quiet_en = 1'b0;
        send(1'b0, 32'h0000_0700, 32'h0, 1000);
        repeat (5) @(negedge clk);
        sw_rst_strobe = 1'b1;
        @(negedge clk);
        sw_rst_strobe = 1'b0;
        chk("R9 pending before bus reset", 65'(stat_rst_pending), 65'(1));
        mdl_on  = 1'b0;
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        exp_q.delete();
        retries_left = 0;
        seen_retry   = 1'b0;
        prev_retry   = 1'b0;
        exp_cnt      = 0;
        chk("R9 bus_req cleared", 65'(bus_req), 65'(0));
        chk("R9 count cleared", 65'(stat_retry_cnt), 65'(0));
        chk("R9 pending cleared", 65'(stat_rst_pending), 65'(0));
        chk("R9 disabled", 65'(stat_enabled), 65'(0));
        chk("R9 no response", 65'(rsp_valid), 65'(0));
        mdl_on = 1'b1;

        pulse_enable();
        send(1'b0, 32'h0000_0800, 32'h0, 2);
        drain();
        summary();
    end

endmodule